// File: doc/BRIEF.md
# Event Status and Interrupt Register Bank

This block is the register front end of a bus controller. A transfer engine reports conditions such as completion, a missing acknowledge or lost arbitration as one-cycle pulses. The bank latches each pulse into a sticky status bit. It holds an enable per condition and drives one level-sensitive interrupt line. A second register carries queue control bits that the engine reads.

Software reaches each register through three addresses. A plain write at the base loads the register. A write to base+4 sets every bit given as 1. A write to base+8 clears every bit given as 1. Interrupt service needs no read-modify-write: software reads the event register and writes the status part of that value to the clear alias. That acknowledges exactly the conditions it saw. A condition that arrives during the acknowledge stays pending.

Top module: `evt_irq_regbank`

## Requirements
- R1: After reset, every register reads zero, the interrupt output is low and both queue control outputs are low.
- R2: The event register sits at base 0x40 and holds 16 bits. Bits 15:8 are enables and bits 7:0 are status. Bits 31:16 read as zero and ignore writes. A plain write to 0x40 loads bits 15:0.
- R3: A write to 0x44 sets each bit of the event register whose write-data bit is 1 and leaves the other bits unchanged.
- R4: A write to 0x48 clears each bit of the event register whose write-data bit is 1. Writing back the status byte that was read acknowledges exactly those events and leaves the enables intact.
- R5: A one-cycle pulse on `evt_pulse[i]` sets status bit i. The bit then holds until software clears or reloads it. Status bit meanings: 7 bus idle, 6 engine done, 5 address not acknowledged, 4 oversize end, 3 early end, 2 arbitration lost, 1 stop seen as target, 0 target event.
- R6: When an event pulse and a clear or load of the same status bit fall in one cycle, the bit ends up set.
- R7: `irq_o` is a register that equals the OR over i of (status[i] AND enable[i]) as seen one cycle earlier. It therefore changes one clock after the register change that causes it.
- R8: A status bit whose enable (bit i+8) is 0 does not raise `irq_o`.
- R9: The queue control register uses base 0x60, set alias 0x64 and clear alias 0x68, and stores all 32 bits. Bit 5 drives `queue_run_o` and bit 2 drives `queue_mode_o`. Event pulses do not change it.
- R10: A read from the base or either alias of a register returns that register's value. A read from any other address returns 0, and a write to any other address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_we | input | 1 | Write strobe for the current cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| evt_pulse | input | 8 | One-cycle event pulses from the transfer engine |
| irq_o | output | 1 | Registered interrupt level |
| queue_run_o | output | 1 | Queue run control bit |
| queue_mode_o | output | 1 | Queue mode control bit |

## Verification
The bench builds the bank with its default parameters: 8 events, an 8-bit address, and bases 0x40 and 0x60. With these values the bench can test every status and enable bit, all six alias addresses and unmapped addresses between the registers with short literal vectors. It also reaches the collision of an event with a clear in the same cycle, the one-clock lag of the interrupt behind the register, and the full 32-bit width of the queue control register.

// File: rtl/evtreg_pkg.sv
package evtreg_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } alias_op_t;

  // Next register value for a given alias operation, before events are merged.
  function automatic logic [31:0] alias_next(logic [31:0] cur, alias_op_t op,
                                             logic [31:0] wd);
    case (op)
      OP_LOAD: alias_next = wd;
      OP_SET:  alias_next = cur | wd;
      OP_CLR:  alias_next = cur & ~wd;
      default: alias_next = cur;
    endcase
  endfunction

  // Interrupt request term: any enabled and pending status bit.
  function automatic logic pending_any(logic [15:0] st, logic [15:0] en);
    pending_any = |(st & en);
  endfunction

endpackage

// File: rtl/alias_dec.sv
module alias_dec
  import evtreg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BASE   = 'h40
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              hit,
  output alias_op_t         op
);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE + 4);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE + 8);

  always_comb begin
    hit = (addr == A_BASE) || (addr == A_SET) || (addr == A_CLR);
    op  = OP_NONE;
    if (we) begin
      if (addr == A_BASE)     op = OP_LOAD;
      else if (addr == A_SET) op = OP_SET;
      else if (addr == A_CLR) op = OP_CLR;
    end
  end
endmodule

// File: rtl/alias_reg.sv
module alias_reg
  import evtreg_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  alias_op_t    op,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] q
);
  // Events are ORed after the alias operation, so a set beats a clear.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= W'(alias_next(32'(q), op, 32'(wdata))) | evt;
  end
endmodule

// File: rtl/irq_gen.sv
module irq_gen
  import evtreg_pkg::*;
#(
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] status,
  input  logic [NUM_EVT-1:0] enable,
  output logic               irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= pending_any(16'(status), 16'(enable));
  end
endmodule

// File: rtl/evt_irq_regbank.sv
module evt_irq_regbank
  import evtreg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_EVT   = 8,
  parameter int EVT_BASE  = 'h40,
  parameter int QCTL_BASE = 'h60,
  parameter int RUN_BIT   = 5,
  parameter int QMODE_BIT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  output logic               irq_o,
  output logic               queue_run_o,
  output logic               queue_mode_o
);
  localparam int EVT_W = 2 * NUM_EVT;

  // Named internal events for the checker.
  alias_op_t          evt_op;
  alias_op_t          qctl_op;
  logic               evt_hit;
  logic               qctl_hit;
  logic [EVT_W-1:0]   evt_q;
  logic [31:0]        qctl_q;
  logic [NUM_EVT-1:0] status_q;
  logic [NUM_EVT-1:0] enable_q;

  alias_dec #(.ADDR_W(ADDR_W), .BASE(EVT_BASE)) u_dec_evt (
    .addr(reg_addr), .we(reg_we), .hit(evt_hit), .op(evt_op)
  );

  alias_dec #(.ADDR_W(ADDR_W), .BASE(QCTL_BASE)) u_dec_qctl (
    .addr(reg_addr), .we(reg_we), .hit(qctl_hit), .op(qctl_op)
  );

  alias_reg #(.W(EVT_W)) u_evt_reg (
    .clk(clk), .rst_n(rst_n), .op(evt_op),
    .wdata(reg_wdata[EVT_W-1:0]), .evt(EVT_W'(evt_pulse)), .q(evt_q)
  );

  alias_reg #(.W(32)) u_qctl_reg (
    .clk(clk), .rst_n(rst_n), .op(qctl_op),
    .wdata(reg_wdata), .evt('0), .q(qctl_q)
  );

  assign status_q = evt_q[NUM_EVT-1:0];
  assign enable_q = evt_q[EVT_W-1:NUM_EVT];

  irq_gen #(.NUM_EVT(NUM_EVT)) u_irq (
    .clk(clk), .rst_n(rst_n), .status(status_q), .enable(enable_q), .irq(irq_o)
  );

  always_comb begin
    if (evt_hit)       reg_rdata = 32'(evt_q);
    else if (qctl_hit) reg_rdata = qctl_q;
    else               reg_rdata = '0;
  end

  assign queue_run_o  = qctl_q[RUN_BIT];
  assign queue_mode_o = qctl_q[QMODE_BIT];
endmodule

// File: rtl/evtreg_chk.sv
module evtreg_chk
  import evtreg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_EVT  = 8,
  parameter int EVT_BASE = 'h40
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic               irq_o,
  input alias_op_t          evt_op,
  input logic [NUM_EVT-1:0] status_q,
  input logic [NUM_EVT-1:0] enable_q
);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(EVT_BASE + 4);

  // R5: a pending bit is kept unless software clears or reloads the register
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_op != OP_CLR && evt_op != OP_LOAD) |=>
      ((status_q & $past(status_q)) == $past(status_q)));

  // R5 and R6: a pulse always leaves its bit set, whatever the write did
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse)));

  // R4: bits named in a clear, with no event in the same cycle, are gone
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_op == OP_CLR) |=>
      ((status_q & $past(reg_wdata[NUM_EVT-1:0] & ~evt_pulse)) == '0));

  // R7: an enabled pending event raises the line on the following clock
  p_irq_lag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(status_q & enable_q)) |=> irq_o);

  // R8: with nothing enabled and pending, the line is low next clock
  p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & enable_q) == '0) |=> !irq_o);

  // R10: the set alias reads back the event register contents
  p_alias_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_SET) |-> (reg_rdata == 32'({enable_q, status_q})));
endmodule

bind evt_irq_regbank evtreg_chk #(
  .ADDR_W(ADDR_W), .NUM_EVT(NUM_EVT), .EVT_BASE(EVT_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .evt_pulse(evt_pulse), .irq_o(irq_o),
  .evt_op(evt_op), .status_q(status_q), .enable_q(enable_q)
);

// File: tb/evt_irq_regbank_tb_top.sv
module evt_irq_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  evt_pulse = '0;
  logic        irq_o, queue_run_o, queue_mode_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  evt_irq_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .irq_o(irq_o), .queue_run_o(queue_run_o), .queue_mode_o(queue_mode_o)
  );

  // Row layout: {we, write addr, write data, event, read addr, expected read}
  localparam int NV = 12;
  localparam logic [88:0] VEC [NV] = '{
    {1'b1, 8'h40, 32'hFFFF_A5C3, 8'h00, 8'h40, 32'h0000_A5C3}, // R2 load, upper dropped
    {1'b1, 8'h44, 32'h0000_0A0C, 8'h00, 8'h44, 32'h0000_AFCF}, // R3 set, R10 alias read
    {1'b1, 8'h48, 32'h0000_0F03, 8'h00, 8'h48, 32'h0000_A0CC}, // R4 clear
    {1'b0, 8'h00, 32'h0000_0000, 8'h11, 8'h40, 32'h0000_A0DD}, // R5 events
    {1'b1, 8'h48, 32'h0000_00FF, 8'h01, 8'h40, 32'h0000_A001}, // R6 event beats clear
    {1'b1, 8'h50, 32'hFFFF_FFFF, 8'h00, 8'h40, 32'h0000_A001}, // R10 unmapped write
    {1'b1, 8'h40, 32'h0000_0000, 8'h00, 8'h50, 32'h0000_0000}, // R10 unmapped read
    {1'b1, 8'h60, 32'h1234_5678, 8'h00, 8'h60, 32'h1234_5678}, // R9 load
    {1'b1, 8'h64, 32'h8000_0004, 8'h00, 8'h64, 32'h9234_567C}, // R9 set
    {1'b1, 8'h68, 32'hFFFF_FFFF, 8'h00, 8'h68, 32'h0000_0000}, // R9 clear
    {1'b0, 8'h00, 32'h0000_0000, 8'hFF, 8'h40, 32'h0000_00FF}, // R5 all events
    {1'b0, 8'h00, 32'h0000_0000, 8'h00, 8'h60, 32'h0000_0000}  // R9 events ignored
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                     input logic [7:0] e);
    @(negedge clk);
    reg_we = we; reg_addr = a; reg_wdata = d; evt_pulse = e;
    @(negedge clk);
    reg_we = 1'b0; evt_pulse = '0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1 reset state
    rd(8'h40, v); chk("R1 event reg", v, 32'h0);
    rd(8'h60, v); chk("R1 queue reg", v, 32'h0);
    chk("R1 irq", 32'(irq_o), 32'h0);
    chk("R1 queue outs", 32'({queue_run_o, queue_mode_o}), 32'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][88], VEC[i][87:80], VEC[i][79:48], VEC[i][47:40]);
      rd(VEC[i][39:32], v);
      chk($sformatf("R2/R3/R4/R5/R6/R9/R10 row %0d", i), v, VEC[i][31:0]);
    end

    // Status 0xFF, enables 0: masked
    chk("R8 masked irq", 32'(irq_o), 32'h0);
    cyc(1'b1, 8'h44, 32'h0000_0400, 8'h00);
    chk("R7 irq lags enable", 32'(irq_o), 32'h0);
    @(negedge clk);
    chk("R7 irq rises", 32'(irq_o), 32'h1);
    cyc(1'b1, 8'h48, 32'h0000_0004, 8'h00);
    chk("R7 irq lags clear", 32'(irq_o), 32'h1);
    @(negedge clk);
    chk("R7 irq falls", 32'(irq_o), 32'h0);

    // R4 acknowledge by writing back what was read
    rd(8'h40, v); chk("R4 before ack", v, 32'h0000_04FB);
    cyc(1'b1, 8'h48, v & 32'h0000_00FF, 8'h00);
    rd(8'h40, v); chk("R4 after ack", v, 32'h0000_0400);

    // R9 queue control outputs
    cyc(1'b1, 8'h64, 32'h0000_0024, 8'h00);
    chk("R9 run/mode set", 32'({queue_run_o, queue_mode_o}), 32'h3);
    cyc(1'b1, 8'h68, 32'h0000_0020, 8'h00);
    chk("R9 run cleared", 32'({queue_run_o, queue_mode_o}), 32'h1);

    // R1 reset in the middle of activity
    cyc(1'b0, 8'h00, 32'h0, 8'h04);
    do_reset();
    rd(8'h40, v); chk("R1 event reg after reset", v, 32'h0);
    rd(8'h60, v); chk("R1 queue reg after reset", v, 32'h0);
    chk("R1 irq after reset", 32'(irq_o), 32'h0);

    finish_run();
  end
endmodule